// File: doc/BRIEF.md
# ADC Overrange Detection Monitor

This block watches the sample path of a sigma-delta converter for input overload. It has two detectors. The slow one takes each sample from the first decimation stage, before gain or offset correction, forms its magnitude and compares it with a programmable 16-bit threshold. The fast one counts consecutive modulator-rate samples that the modulator reports as beyond full scale. If either detector fires, a sticky overrange flag is set.

Each decimator sample is passed to the output one cycle later together with a data-valid qualifier. The qualifier is low while the overrange flag is set. The host sees the flag at bit 8 of a 16-bit status word. A status read arms the clear. The flag then drops only when the next decimator sample is clean.

Top module: `ovr_monitor`

## Requirements
- R1: After reset, the threshold holds 0xCCCC, the overrange flag is 0, the run counter is 0 and `out_vld` and `out_dvalid` are low.
- R2: The magnitude of `dec_data` (two's complement) is its absolute value, with 0x8000 saturating to 0x7FFF. That value is shifted left by one bit to fill 16 bits, so 0x7FFF becomes 0xFFFE. A sample is over range only when this scaled magnitude is strictly greater than the threshold.
- R3: A strobed decimator sample that is over range sets the overrange flag at the same clock edge that registers the sample.
- R4: `out_vld` pulses one cycle after each `dec_vld`, and `out_data` carries that sample. `out_dvalid` equals `out_vld` AND NOT the overrange flag, so a sample that trips the flag is already marked invalid.
- R5: A `mod_vld` strobe with `mod_full`=1 increments a run counter. A strobe with `mod_full`=0 resets it to zero. Idle cycles leave it unchanged. The strobe that makes the run exceed 4 sets the flag at its edge, and so does every further full strobe.
- R6: The flag is sticky. A `stat_rd` pulse while the flag is set arms a clear. The next decimator sample clears the flag if it is clean, and the arming is used up whether or not the flag clears.
- R7: A write with `reg_we`=1 and `reg_addr`=1 loads `reg_wdata` into the threshold. Writes to any other address are ignored. A sample strobed in the same cycle as the write still uses the old threshold.
- R8: `status_word` reads {ID_CODE[4:0], 1'b0, 1'b0, flag, 8'h00}. Bit 10 is always 0 and bit 8 is the flag.
- R9: A detection in the same cycle as a pending clear wins, so the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_vld | input | 1 | Decimator sample strobe |
| dec_data | input | 16 | Decimator sample, two's complement |
| mod_vld | input | 1 | Modulator-rate strobe |
| mod_full | input | 1 | Modulator input beyond full scale |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| stat_rd | input | 1 | Status read strobe, arms the clear |
| out_vld | output | 1 | Output sample strobe |
| out_data | output | 16 | Output sample |
| out_dvalid | output | 1 | Data-valid qualifier |
| status_word | output | 16 | Status word with the overrange flag |

## Verification
All results are due one clock edge after their stimulus. The flag, the run counter and the threshold all change at the edge that captures the strobe. The output sample and its qualifier appear in the cycle after `dec_vld`. The bench drives inputs 1 ns after a rising edge. It reads `status_word` in the next cycle, before the edge that applies `stat_rd`. A monitor pops the expected qualifier and data on every falling edge where `out_vld` is high.

// File: rtl/ovr_monitor.sv
module ovr_monitor #(
  parameter int          DW       = 16,
  parameter int          AW       = 2,
  parameter logic [AW-1:0] THR_ADDR = 2'd1,
  parameter logic [DW-1:0] THR_RST  = 16'hCCCC,
  parameter int          RUN_LEN  = 4,
  parameter logic [4:0]  ID_CODE  = 5'd3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec_vld,
  input  logic [DW-1:0] dec_data,
  input  logic          mod_vld,
  input  logic          mod_full,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          stat_rd,
  output logic          out_vld,
  output logic [DW-1:0] out_data,
  output logic          out_dvalid,
  output logic [15:0]   status_word
);
  localparam int CW = $clog2(RUN_LEN + 2);
  localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] MOST_POS = {1'b0, {(DW-1){1'b1}}};

  logic [DW-1:0] thr_q;
  logic [CW-1:0] run_q;
  logic          ovr_q, pend_q;
  logic          ovr_d, pend_d;

  wire [DW-1:0] abs_w = !dec_data[DW-1] ? dec_data :
                        (dec_data == MOST_NEG) ? MOST_POS : -dec_data;
  wire [DW-1:0] mag_w = {abs_w[DW-2:0], 1'b0};
  wire dec_hit = dec_vld && (mag_w > thr_q);
  wire mod_hit = mod_vld && mod_full && (run_q >= CW'(RUN_LEN));

  always_comb begin
    ovr_d  = ovr_q;
    pend_d = pend_q;
    if (stat_rd && ovr_q) pend_d = 1'b1;
    if (dec_vld && pend_q && !dec_hit) ovr_d = 1'b0;
    if (dec_vld || mod_hit) pend_d = 1'b0;
    if (dec_hit || mod_hit) ovr_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q    <= THR_RST;
      run_q    <= '0;
      ovr_q    <= 1'b0;
      pend_q   <= 1'b0;
      out_vld  <= 1'b0;
      out_data <= '0;
    end else begin
      if (reg_we && reg_addr == THR_ADDR) thr_q <= reg_wdata;
      if (mod_vld) begin
        if (!mod_full) run_q <= '0;
        else if (run_q != CW'(RUN_LEN + 1)) run_q <= run_q + 1'b1;
      end
      ovr_q   <= ovr_d;
      pend_q  <= pend_d;
      out_vld <= dec_vld;
      if (dec_vld) out_data <= dec_data;
    end
  end

  assign out_dvalid  = out_vld && !ovr_q;
  assign status_word = {ID_CODE, 1'b0, 1'b0, ovr_q, 8'h00};

  AST_DEC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld && (mag_w > thr_q) |=> status_word[8]); // R3
  AST_HIT_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    dec_hit |=> out_vld && !out_dvalid); // R4
  AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld |=> out_vld && out_data == $past(dec_data)); // R4
  AST_RUN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    mod_vld && mod_full && run_q >= CW'(RUN_LEN) |=> ovr_q); // R5
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q && !pend_q |=> ovr_q); // R6
  AST_RUN_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
    mod_vld && !mod_full |=> run_q == '0); // R5
endmodule

// File: tb/test_ovr_monitor.sv
module test_ovr_monitor;
  logic clk = 0, rst_n = 0;
  logic dec_vld = 0, mod_vld = 0, mod_full = 0, reg_we = 0, stat_rd = 0;
  logic [15:0] dec_data = 0, reg_wdata = 0;
  logic [1:0]  reg_addr = 0;
  logic out_vld, out_dvalid;
  logic [15:0] out_data, status_word;

  ovr_monitor i_ovr_monitor (.clk, .rst_n, .dec_vld, .dec_data, .mod_vld, .mod_full,
    .reg_we, .reg_addr, .reg_wdata, .stat_rd, .out_vld, .out_data, .out_dvalid, .status_word);

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  logic [16:0] expq[$];
  logic [15:0] m_thr = 16'hCCCC;
  logic m_ovr = 0, m_pend = 0;
  int m_run = 0;

  function automatic logic [15:0] smag(logic [15:0] d);
    logic [15:0] a;
    a = !d[15] ? d : (d == 16'h8000) ? 16'h7FFF : -d;
    return {a[14:0], 1'b0};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(bit dv, logic [15:0] d, bit mv, bit mf, bit rd, bit we, logic [1:0] a, logic [15:0] wd);
    bit dh, mh;
    dh = dv && (smag(d) > m_thr);
    mh = 0;
    if (mv) begin
      if (mf) begin m_run = (m_run < 5) ? m_run + 1 : 5; mh = (m_run >= 5); end
      else m_run = 0;
    end
    if (rd && m_ovr) m_pend = 1;
    if (dv && m_pend && !dh) m_ovr = 0;
    if (dv || mh) m_pend = 0;
    if (dh || mh) m_ovr = 1;
    if (we && a == 2'd1) m_thr = wd;
    if (dv) expq.push_back({!m_ovr, d});
    dec_vld = dv; dec_data = d; mod_vld = mv; mod_full = mf;
    stat_rd = rd; reg_we = we; reg_addr = a; reg_wdata = wd;
    @(posedge clk); #1;
    dec_vld = 0; mod_vld = 0; mod_full = 0; stat_rd = 0; reg_we = 0;
  endtask

  task automatic sample(logic [15:0] d); step(1, d, 0, 0, 0, 0, 0, 0); endtask
  task automatic modv(bit f); step(0, 0, 1, f, 0, 0, 0, 0); endtask
  task automatic idle(); step(0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic rd_status(string req);
    check(req, status_word, {5'd3, 2'b00, m_ovr, 8'h00});
    step(0, 0, 0, 0, 1, 0, 0, 0);
  endtask

  always @(negedge clk) if (rst_n && out_vld) begin
    if (expq.size() == 0) check("R4 unexpected out_vld", 1, 0);
    else begin
      logic [16:0] e;
      e = expq.pop_front();
      check("R4 dvalid/data", {out_dvalid, out_data}, e);
    end
  end

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    check("R1 status", status_word, 16'h1800);
    check("R1 out_vld", {out_vld, out_dvalid}, 0);
    sample(16'h0100); sample(16'hF000);
    sample(16'h6665); sample(16'h6666);
    rd_status("R2 boundary clean");
    sample(16'h6667);
    rd_status("R3 set");
    sample(16'h0010); sample(16'h0020);
    rd_status("R6 cleared after read");
    sample(16'h8000);
    rd_status("R2 most negative sets");
    sample(16'h8000);
    rd_status("R6 re-hit keeps flag");
    sample(16'h0001);
    rd_status("R8 bit8 clear");
    step(0, 0, 0, 0, 0, 1, 2'd1, 16'hFFFE);
    sample(16'h8000);
    rd_status("R7 new threshold");
    step(0, 0, 0, 0, 0, 1, 2'd2, 16'h0000);
    sample(16'h4000);
    rd_status("R7 other address ignored");
    step(1, 16'h0081, 0, 0, 0, 1, 2'd1, 16'h0100);
    rd_status("R7 same-cycle uses old");
    sample(16'h0081);
    rd_status("R7 later sample uses new");
    step(0, 0, 0, 0, 0, 1, 2'd1, 16'hCCCC);
    sample(16'h0001);
    rd_status("R6 clear after threshold test");
    repeat (4) modv(1);
    modv(0);
    repeat (4) modv(1);
    rd_status("R5 four then break, no set");
    idle(); idle();
    modv(1);
    rd_status("R5 fifth with gap sets");
    step(1, 16'h0001, 1, 1, 0, 0, 0, 0);
    rd_status("R9 detection beats clear");
    modv(0);
    sample(16'h0002);
    rd_status("R6 final clear");
    idle(); idle();
    check("R4 queue drained", expq.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule